// File: doc/BRIEF.md
# Shared-Pin Subscriber Line Control Sequencer

This block serves four subscriber-line channels through one common group of parallel control pins and one common pair of status pins. A host fills a small register file with one control entry per channel. The block then time-shares the common state-control and relay-control outputs among the channels. It places a channel's entry on the shared pins and then pulses that channel's active-low latch enable. The external per-channel latches are transparent while their enable is low and hold their data once it returns high.

While a channel's enable is low, the block also samples two shared inputs: a loop-status line and an active-low thermal flag. It combines the thermal flag with that channel's own dedicated thermal input and keeps the results in an 8-bit status word. When the host opens an eight-cycle chip-select window, the word is loaded into a serial register on the first falling clock edge and shifted out one bit per cycle. The host window also takes over the enable sequencing. Each window carries exactly one enable pulse. If the window opens in the middle of a pulse, that pulse is cut short and the window's pulse is given to the same channel again.

Top module: `line_ctl_mux`

## Requirements
- R1: While reset is asserted, all four enables are high, the control outputs and the serial output are 0, and the status word is cleared. After reset is released, the first enable pulse goes to channel 0.
- R2: When no host window is open, channels are served in the order 0, 1, 2, 3, 0. Each slot lasts four cycles: one setup cycle, two cycles with that channel's enable low, and one gap cycle. No two enables are ever low at once, and two pulses are never adjacent.
- R3: A host write with host_we high stores host_wdata in the entry of channel host_ch. Bits [1:0] of an entry drive state_ctl and bits [4:2] drive relay_ctl. The entry is on these outputs from the setup cycle onward, so it is valid one cycle before the enable goes low and stays stable while the enable is low. Entries reset to 0.
- R4: On every rising edge at which channel c's enable is low, loop_sense is stored in bit c of the status word.
- R5: On the same edges, the AND of therm_mux_n and therm_line_n[c] is stored in bit 4+c of the status word, so a low on either source records a fault (0).
- R6: On the first falling clock edge at which cs_n is low after being high, the status word is copied into the shift register. stat_sdo then presents bit 7, and each further falling edge with cs_n low moves on to the next lower bit.
- R7: Enables change only on rising clock edges and never on a falling edge.
- R8: The first rising edge that sees cs_n low starts a setup cycle for the pending channel. Exactly one two-cycle pulse follows, and all enables then stay high until cs_n returns high. After the window closes, a setup cycle runs and the next channel in order is served.
- R9: If cs_n falls while some enable is low, that enable goes high at the first rising edge that sees cs_n low. The pulse inside the window is then given to that same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register-file write strobe |
| host_ch | input | 2 | Channel index of the write |
| host_wdata | input | 5 | Entry: [1:0] state control, [4:2] relay control |
| cs_n | input | 1 | Active-low host chip-select window |
| loop_sense | input | 1 | Shared multiplexed loop status |
| therm_mux_n | input | 1 | Shared multiplexed thermal flag, active low |
| therm_line_n | input | 4 | Per-line thermal flags, active low |
| latch_en_n | output | 4 | Per-channel latch enables, active low |
| state_ctl | output | 2 | Shared state-control bits |
| relay_ctl | output | 3 | Shared relay-control bits |
| stat_sdo | output | 1 | Serial status output |

## Verification
A wrong slot state or channel pointer shows on latch_en_n within one cycle: a pulse goes to the wrong channel, lasts the wrong number of cycles, or merges with its neighbour. A stale control entry shows on state_ctl and relay_ctl during the setup cycle, one cycle before that channel's enable falls. A faulty capture does not show until the next chip-select window. The bad bit then appears on stat_sdo in the serial cycle given by its position, from one to eight falling edges after the window opens. An abort that is handled wrongly shows either as an enable still low at the first edge of the window or as the window's pulse landing on the next channel instead of the interrupted one.

// File: rtl/line_ctl_pkg.sv
package line_ctl_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_SETUP = 2'd1,
      SLOT_LOW   = 2'd2,
      SLOT_GAP   = 2'd3
   } slot_e;

endpackage

// File: rtl/line_ctl_regfile.sv
module line_ctl_regfile #(
   parameter int NCH   = 4,
   parameter int ENT_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(NCH)-1:0]   wch,
   input  logic [ENT_W-1:0]         wdata,
   input  logic [$clog2(NCH)-1:0]   rptr,
   output logic [ENT_W-1:0]         rdata
);
   logic [ENT_W-1:0] mem_q [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[wch] <= wdata;
      end
   end

   assign rdata = mem_q[rptr];
endmodule

// File: rtl/line_slot_sched.sv
module line_slot_sched
   import line_ctl_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int ENT_W     = 5,
   parameter int PULSE_LEN = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   output logic [$clog2(NCH)-1:0]   rd_ptr,
   input  logic [ENT_W-1:0]         rd_entry,
   output logic [NCH-1:0]           en_n,
   output logic [ENT_W-1:0]         ctl
);
   localparam int CHW  = $clog2(NCH);
   localparam int CNTW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
   localparam logic [CHW-1:0]  LAST_CH  = CHW'(NCH - 1);
   localparam logic [CNTW-1:0] LAST_CNT = CNTW'(PULSE_LEN - 1);

   slot_e            st_q, st_d;
   logic [CHW-1:0]   ptr_q, ptr_d;
   logic [CNTW-1:0]  cnt_q, cnt_d;
   logic             cs_q;
   logic             win_start;
   logic             load_ctl;
   logic [NCH-1:0]   en_d;

   // a window begins on the first rising edge that sees chip-select low
   assign win_start = cs_q & ~cs_n;

   always_comb begin
      st_d     = st_q;
      ptr_d    = ptr_q;
      cnt_d    = cnt_q;
      load_ctl = 1'b0;
      if (win_start) begin
         // any pulse in flight is dropped; the same pointer is re-served
         st_d     = SLOT_SETUP;
         cnt_d    = '0;
         load_ctl = 1'b1;
      end else begin
         case (st_q)
            SLOT_IDLE: begin
               st_d     = SLOT_SETUP;
               load_ctl = 1'b1;
            end
            SLOT_SETUP: begin
               st_d  = SLOT_LOW;
               cnt_d = '0;
            end
            SLOT_LOW: begin
               if (cnt_q == LAST_CNT) begin
                  st_d  = SLOT_GAP;
                  ptr_d = (ptr_q == LAST_CH) ? '0 : ptr_q + 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            SLOT_GAP: begin
               // inside a window the single pulse is spent: hold here
               if (cs_n) begin
                  st_d     = SLOT_SETUP;
                  load_ctl = 1'b1;
               end
            end
            default: st_d = SLOT_IDLE;
         endcase
      end
   end

   always_comb begin
      en_d = '1;
      if (st_d == SLOT_LOW) en_d[ptr_d] = 1'b0;
   end

   assign rd_ptr = ptr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SLOT_IDLE;
         ptr_q <= '0;
         cnt_q <= '0;
         cs_q  <= 1'b1;
         en_n  <= '1;
         ctl   <= '0;
      end else begin
         st_q  <= st_d;
         ptr_q <= ptr_d;
         cnt_q <= cnt_d;
         cs_q  <= cs_n;
         en_n  <= en_d;
         if (load_ctl) ctl <= rd_entry;
      end
   end
endmodule

// File: rtl/line_stat_capture.sv
module line_stat_capture #(
   parameter int NCH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   en_n,
   input  logic             loop_sense,
   input  logic             therm_mux_n,
   input  logic [NCH-1:0]   therm_line_n,
   output logic [2*NCH-1:0] word
);
   logic [NCH-1:0] therm_ok;
   logic [NCH-1:0] loop_q;
   logic [NCH-1:0] therm_q;

   for (genvar c = 0; c < NCH; c++) begin : g_merge
      assign therm_ok[c] = therm_mux_n & therm_line_n[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loop_q  <= '0;
         therm_q <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (!en_n[c]) begin
               loop_q[c]  <= loop_sense;
               therm_q[c] <= therm_ok[c];
            end
         end
      end
   end

   assign word = {therm_q, loop_q};
endmodule

// File: rtl/line_stat_shifter.sv
module line_stat_shifter #(
   parameter int SW        = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic [SW-1:0] word,
   output logic          sdo
);
   logic [SW-1:0] sr_q;
   logic [SW-1:0] sr_next;
   logic          cs_nq;

   if (MSB_FIRST) begin : g_msb
      assign sdo     = sr_q[SW-1];
      assign sr_next = {sr_q[SW-2:0], 1'b0};
   end else begin : g_lsb
      assign sdo     = sr_q[0];
      assign sr_next = {1'b0, sr_q[SW-1:1]};
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cs_nq <= 1'b1;
      end else begin
         cs_nq <= cs_n;
         if (!cs_n) sr_q <= cs_nq ? word : sr_next;
      end
   end
endmodule

// File: rtl/line_ctl_mux.sv
module line_ctl_mux #(
   parameter int NCH       = 4,
   parameter int ST_W      = 2,
   parameter int RLY_W     = 3,
   parameter int PULSE_LEN = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_we,
   input  logic [$clog2(NCH)-1:0]   host_ch,
   input  logic [ST_W+RLY_W-1:0]    host_wdata,
   input  logic                     cs_n,
   input  logic                     loop_sense,
   input  logic                     therm_mux_n,
   input  logic [NCH-1:0]           therm_line_n,
   output logic [NCH-1:0]           latch_en_n,
   output logic [ST_W-1:0]          state_ctl,
   output logic [RLY_W-1:0]         relay_ctl,
   output logic                     stat_sdo
);
   localparam int CHW   = $clog2(NCH);
   localparam int ENT_W = ST_W + RLY_W;
   localparam int SW    = 2 * NCH;

   if (NCH < 2) begin : g_bad_nch
      $error("line_ctl_mux: NCH must be at least 2");
   end
   if (PULSE_LEN < 1 || PULSE_LEN + 2 > SW) begin : g_bad_pulse
      $error("line_ctl_mux: setup, pulse and gap must fit the window");
   end
   if (ST_W < 1 || RLY_W < 1) begin : g_bad_ctl
      $error("line_ctl_mux: control fields need at least one bit");
   end

   logic [CHW-1:0]   rd_ptr;
   logic [ENT_W-1:0] rd_entry;
   logic [ENT_W-1:0] ctl;
   logic [SW-1:0]    word;

   line_ctl_regfile #(.NCH(NCH), .ENT_W(ENT_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_we),
      .wch   (host_ch),
      .wdata (host_wdata),
      .rptr  (rd_ptr),
      .rdata (rd_entry)
   );

   line_slot_sched #(.NCH(NCH), .ENT_W(ENT_W), .PULSE_LEN(PULSE_LEN)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .rd_ptr   (rd_ptr),
      .rd_entry (rd_entry),
      .en_n     (latch_en_n),
      .ctl      (ctl)
   );

   line_stat_capture #(.NCH(NCH)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_n         (latch_en_n),
      .loop_sense   (loop_sense),
      .therm_mux_n  (therm_mux_n),
      .therm_line_n (therm_line_n),
      .word         (word)
   );

   line_stat_shifter #(.SW(SW), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .word  (word),
      .sdo   (stat_sdo)
   );

   assign state_ctl = ctl[ST_W-1:0];
   assign relay_ctl = ctl[ENT_W-1:ST_W];
endmodule

// File: rtl/line_ctl_mux_chk.sv
module line_ctl_mux_chk #(
   parameter int NCH   = 4,
   parameter int ENT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic [NCH-1:0]   latch_en_n,
   input logic [ENT_W-1:0] ctl
);
   logic [NCH-1:0] en_at_fall;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_at_fall <= '1;
      else        en_at_fall <= latch_en_n;
   end

   AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~latch_en_n) <= 1); // R2

   AST_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en_n != '1) |=> (latch_en_n == '1 || $stable(latch_en_n))); // R2

   AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en_n != '1) |-> $stable(ctl)); // R3

   AST_EN_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en_n == en_at_fall); // R7

   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && latch_en_n != '1) |=> (latch_en_n == '1)); // R9
endmodule

bind line_ctl_mux line_ctl_mux_chk #(.NCH(NCH), .ENT_W(ST_W + RLY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .latch_en_n (latch_en_n),
   .ctl        ({relay_ctl, state_ctl})
);

// File: tb/sim_line_ctl_mux.sv
`timescale 1ns/1ps
module sim_line_ctl_mux;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_ch = '0;
   logic [4:0] host_wdata = '0;
   logic       cs_n = 1'b1;
   logic       loop_sense = 1'b0;
   logic       therm_mux_n = 1'b1;
   logic [3:0] therm_line_n = 4'hF;
   logic [3:0] latch_en_n;
   logic [1:0] state_ctl;
   logic [2:0] relay_ctl;
   logic       stat_sdo;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [3:0] lp, tm, tl;
   logic [4:0] ent [4];

   always #4 clk = ~clk;

   line_ctl_mux u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_ch(host_ch),
      .host_wdata(host_wdata), .cs_n(cs_n), .loop_sense(loop_sense),
      .therm_mux_n(therm_mux_n), .therm_line_n(therm_line_n),
      .latch_en_n(latch_en_n), .state_ctl(state_ctl), .relay_ctl(relay_ctl),
      .stat_sdo(stat_sdo)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // sample and drive point: 6 ns after a rising edge, after the falling edge
   task automatic step();
      @(posedge clk);
      #6;
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      cs_n    = 1'b1;
      host_we = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic drive_stat();
      loop_sense  = 1'b1;
      therm_mux_n = 1'b0;
      for (int c = 0; c < 4; c++) begin
         if (!latch_en_n[c]) begin
            loop_sense  = lp[c];
            therm_mux_n = tm[c];
         end
      end
      therm_line_n = tl;
   endtask

   function automatic logic [3:0] rr_en(input int s);
      int ph = (s - 1) % 4;
      int ch = ((s - 1) / 4) % 4;
      rr_en = 4'hF;
      if (ph == 1 || ph == 2) rr_en[ch] = 1'b0;
   endfunction

   task automatic t_roundrobin();
      ent[0] = 5'b10110; ent[1] = 5'b01001; ent[2] = 5'b11100; ent[3] = 5'b00011;
      do_reset();
      host_we = 1'b1; host_ch = 2'd0; host_wdata = ent[0];
      for (int s = 1; s <= 24; s++) begin
         step();
         check(latch_en_n == rr_en(s), "R2", "round-robin enable", latch_en_n, rr_en(s));
         if ((s - 1) % 4 != 3) begin
            logic [4:0] e;
            e = (s <= 4) ? 5'b0 : ent[((s - 1) / 4) % 4];
            check({relay_ctl, state_ctl} == e, "R3", "control entry on shared pins",
                  {relay_ctl, state_ctl}, e);
         end
         if (s < 4) begin
            host_ch = 2'(s); host_wdata = ent[s];
         end else begin
            host_we = 1'b0;
         end
      end
   endtask

   task automatic read_window(input logic [7:0] w, input string tag);
      cs_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         step();
         check(stat_sdo == w[7-k], (7 - k) >= 4 ? "R5" : "R4",
               $sformatf("%s serial bit %0d (R6 order)", tag, 7 - k), stat_sdo, w[7-k]);
         drive_stat();
      end
      cs_n = 1'b1;
   endtask

   task automatic t_status();
      do_reset();
      lp = 4'b1001; tm = 4'b1101; tl = 4'b0111;
      drive_stat();
      for (int s = 0; s < 16; s++) begin step(); drive_stat(); end
      read_window({tm & tl, lp}, "pattern A");
      lp = 4'b0110; tm = 4'b1011; tl = 4'b1110;
      drive_stat();
      for (int s = 0; s < 16; s++) begin step(); drive_stat(); end
      read_window({tm & tl, lp}, "pattern B");
   endtask

   task automatic t_reset();
      lp = 4'hF; tm = 4'hF; tl = 4'hF;
      loop_sense = 1'b1; therm_mux_n = 1'b1; therm_line_n = 4'hF;
      rst_n = 1'b0;
      cs_n  = 1'b0;
      step();
      step();
      check(latch_en_n == 4'hF, "R1", "enables during reset", latch_en_n, 4'hF);
      check({relay_ctl, state_ctl} == 5'b0, "R1", "controls during reset",
            {relay_ctl, state_ctl}, 0);
      check(stat_sdo == 1'b0, "R1", "serial out during reset", stat_sdo, 0);
      rst_n = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         step();
         check(stat_sdo == 1'b0, "R1", $sformatf("cleared word bit %0d", 8 - k), stat_sdo, 0);
         if (k == 1) check(latch_en_n == 4'hF, "R1", "setup after reset", latch_en_n, 4'hF);
         if (k == 2) check(latch_en_n == 4'b1110, "R1", "channel 0 first", latch_en_n, 4'b1110);
      end
      cs_n = 1'b1;
   endtask

   task automatic t_abort();
      do_reset();
      for (int s = 1; s <= 6; s++) step();
      check(latch_en_n == 4'b1101, "R9", "channel 1 pulse in flight", latch_en_n, 4'b1101);
      cs_n = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         logic [3:0] e;
         step();
         e = (k == 2 || k == 3) ? 4'b1101 : 4'hF;
         check(latch_en_n == e, (k <= 3) ? "R9" : "R8",
               $sformatf("abort window cycle %0d", k), latch_en_n, e);
      end
      cs_n = 1'b1;
      step();
      check(latch_en_n == 4'hF, "R8", "setup after window", latch_en_n, 4'hF);
      step();
      check(latch_en_n == 4'b1011, "R8", "next channel after abort", latch_en_n, 4'b1011);
   endtask

   task automatic t_window();
      do_reset();
      for (int s = 1; s <= 4; s++) step();
      cs_n = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         logic [3:0] e;
         step();
         e = (k == 2 || k == 3) ? 4'b1101 : 4'hF;
         check(latch_en_n == e, "R8", $sformatf("window cycle %0d", k), latch_en_n, e);
      end
      cs_n = 1'b1;
      step();
      step();
      check(latch_en_n == 4'b1011, "R8", "resume after window", latch_en_n, 4'b1011);
   endtask

   task automatic t_edges();
      do_reset();
      for (int k = 0; k < 12; k++) begin
         logic [3:0] a, b;
         @(posedge clk);
         #2 a = latch_en_n;
         #4 b = latch_en_n;
         check(a == b, "R7", "enable moved at falling edge", b, a);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      lp = '0; tm = '1; tl = '1;
      for (int i = 0; i < 4; i++) ent[i] = '0;
      t_roundrobin();
      t_status();
      t_reset();
      t_abort();
      t_window();
      t_edges();
      summary();
   end
endmodule